// File: doc/BRIEF.md
# Scanline Ring Queue Controller

This block sits between a line producer and a video streaming path. It owns a ring of scanline slots. The producer claims the slot at the head of the ring and fills in a sync word and up to `MAX_WORDS` data words. It then submits the slot with a length and a repeat count. The streaming side walks the ring from its tail. For each line it sends the sync word, the data words and one all-zero blanking word to a downstream FIFO, using a valid/ready handshake.

Each slot has three lifecycle flags: occupied, submitted and in-flight. It also has a replay count, so one filled line can be sent several times before its slot goes back to the producer. All logic runs in one clock domain. Claims, writes and submits are single-cycle strobes. The producer must not claim when `claim_ok` is low, and it must submit a length no larger than `MAX_WORDS`.

Top module: `line_ring_ctrl`

## Requirements
- R1: After reset, `o_valid` is 0, `claim_ok` is 1 and `claim_slot` is 0.
- R2: Each accepted claim (`claim_req` high while `claim_ok` is high) advances `claim_slot` by one modulo `SLOTS` (32), so slot 31 is followed by slot 0.
- R3: While the head slot is still occupied, `claim_ok` is 0 and a `claim_req` leaves `claim_slot` unchanged.
- R4: A claim presets the slot's sync word to `PRESET_SYNC` and its length and replay count to 0. A line whose sync word was not rewritten after the claim starts with `PRESET_SYNC`.
- R5: A write with `wr_idx` = 0 sets the slot's sync word. A write with `wr_idx` = k (1..`MAX_WORDS`) sets data word k.
- R6: A line is streamed as the sync word, then data words 1..length, then one all-zero word, for length+2 words in total. `o_last` is 1 only on the zero word.
- R7: A line submitted with replay count n is streamed n+1 times back to back before its slot is released.
- R8: A submit to the tail slot while nothing is streaming makes `o_valid` go high at the same clock edge that registers the submit.
- R9: While `o_valid` is 1 and `o_ready` is 0, `o_valid` stays 1 and `o_data` does not change.
- R10: When the last repetition of a line completes, its slot is freed (claimable again) and the tail advances. If the next slot is already submitted, its first word is valid in the very next cycle, with no idle cycle in between.
- R11: Lines are streamed strictly in the order their slots were claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| claim_req | input | 1 | Request to claim the head slot |
| claim_ok | output | 1 | Head slot is free and a claim will be taken |
| claim_slot | output | SW | Index of the head slot |
| wr_en | input | 1 | Word write strobe |
| wr_slot | input | SW | Slot written |
| wr_idx | input | LW | 0 = sync word, k = data word k |
| wr_data | input | DW | Word written |
| sub_en | input | 1 | Submit strobe |
| sub_slot | input | SW | Slot submitted |
| sub_len | input | LW | Number of data words |
| sub_rep | input | RW | Extra replays of the line |
| o_valid | output | 1 | Output word valid |
| o_ready | input | 1 | Downstream accepts the word |
| o_data | output | DW | Output word |
| o_last | output | 1 | Current word is the blanking terminator |
| o_slot | output | SW | Slot being streamed (tail) |

## Verification
Every control result is registered once. A claim moves `claim_slot` and a submit to an idle tail raises `o_valid` at the next rising edge. A word accepted at one edge is replaced by its successor at that same edge. A completing line hands over to a ready successor with no gap. The bench drives all inputs on the falling edge and reads the outputs on the following falling edge, half a cycle after the edge that produced them. Each word is compared at the falling edge before the edge where it is accepted, against an expected-word queue built from the submitted lines and their replay counts.

// File: rtl/lr_pkg.sv
package lr_pkg;
    localparam int FLG_BUSY  = 0;
    localparam int FLG_READY = 1;
    localparam int FLG_START = 2;
    typedef logic [2:0] slot_flags_t;
    localparam slot_flags_t FLAGS_CLAIMED  = 3'b001;
    localparam slot_flags_t FLAGS_STARTABLE = 3'b011;
endpackage

// File: rtl/lr_word_store.sv
module lr_word_store #(
    parameter int SLOTS       = 32,
    parameter int MAX_WORDS   = 8,
    parameter int DW          = 32,
    parameter logic [DW-1:0] PRESET_SYNC = 32'h0002_0000,
    localparam int SW = $clog2(SLOTS),
    localparam int LW = $clog2(MAX_WORDS + 1),
    localparam int PW = $clog2(MAX_WORDS + 2)
) (
    input  logic          clk,
    input  logic          preset_en,
    input  logic [SW-1:0] preset_slot,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_slot,
    input  logic [LW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [SW-1:0] rd_slot,
    input  logic [PW-1:0] rd_ptr,
    input  logic [LW-1:0] rd_len,
    output logic [DW-1:0] rd_word
);
    logic [DW-1:0] sync_mem [SLOTS];
    logic [DW-1:0] data_mem [SLOTS][MAX_WORDS];

    // sync word: claim preset wins over a same-cycle write
    always_ff @(posedge clk) begin
        if (preset_en)
            sync_mem[preset_slot] <= PRESET_SYNC;
        else if (wr_en && wr_idx == '0)
            sync_mem[wr_slot] <= wr_data;
    end

    for (genvar w = 0; w < MAX_WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == LW'(w + 1))
                data_mem[wr_slot][w] <= wr_data;
        end
    end

    // pointer 0: sync, 1..len: data, len+1: zero terminator
    always_comb begin
        rd_word = '0;
        if (rd_ptr == '0) begin
            rd_word = sync_mem[rd_slot];
        end else begin
            for (int w = 0; w < MAX_WORDS; w++) begin
                if (rd_ptr == PW'(w + 1) && PW'(w + 1) <= PW'(rd_len))
                    rd_word = data_mem[rd_slot][w];
            end
        end
    end
endmodule

// File: rtl/line_ring_ctrl.sv
module line_ring_ctrl
    import lr_pkg::*;
#(
    parameter int SLOTS     = 32,
    parameter int MAX_WORDS = 8,
    parameter int DW        = 32,
    parameter int RW        = 4,
    parameter logic [DW-1:0] PRESET_SYNC = 32'h0002_0000,
    localparam int SW = $clog2(SLOTS),
    localparam int LW = $clog2(MAX_WORDS + 1),
    localparam int PW = $clog2(MAX_WORDS + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          claim_req,
    output logic          claim_ok,
    output logic [SW-1:0] claim_slot,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_slot,
    input  logic [LW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic          sub_en,
    input  logic [SW-1:0] sub_slot,
    input  logic [LW-1:0] sub_len,
    input  logic [RW-1:0] sub_rep,
    output logic          o_valid,
    input  logic          o_ready,
    output logic [DW-1:0] o_data,
    output logic          o_last,
    output logic [SW-1:0] o_slot
);
    typedef struct packed {
        logic [SW-1:0]                head;
        logic [SW-1:0]                tail;
        logic                         active;
        logic [PW-1:0]                ptr;
        logic [SLOTS-1:0][2:0]        flags;
        logic [SLOTS-1:0][LW-1:0]     len;
        logic [SLOTS-1:0][RW-1:0]     rep;
    } ring_state_t;

    ring_state_t s_q, s_d;
    logic        claim_fire;
    logic        at_term;

    assign claim_fire = claim_req && !s_q.flags[s_q.head][FLG_BUSY];
    assign at_term    = s_q.ptr == PW'(s_q.len[s_q.tail]) + PW'(1);

    always_comb begin
        s_d = s_q;
        if (claim_fire) begin
            s_d.flags[s_q.head] = FLAGS_CLAIMED;
            s_d.len[s_q.head]   = '0;
            s_d.rep[s_q.head]   = '0;
            s_d.head            = s_q.head + 1'b1;
        end
        if (sub_en) begin
            s_d.flags[sub_slot][FLG_READY] = 1'b1;
            s_d.len[sub_slot] = (sub_len > LW'(MAX_WORDS)) ? LW'(MAX_WORDS) : sub_len;
            s_d.rep[sub_slot] = sub_rep;
        end
        if (s_q.active && o_ready) begin
            if (!at_term) begin
                s_d.ptr = s_q.ptr + 1'b1;
            end else if (s_q.rep[s_q.tail] != '0) begin
                s_d.rep[s_q.tail] = s_q.rep[s_q.tail] - 1'b1;
                s_d.ptr           = '0;
            end else begin
                s_d.flags[s_q.tail][FLG_BUSY] = 1'b0;
                s_d.tail   = s_q.tail + 1'b1;
                s_d.active = 1'b0;
                s_d.ptr    = '0;
            end
        end
        // start the tail line as soon as it is claimed, submitted and not yet sent
        if (!s_d.active && s_d.flags[s_d.tail] == FLAGS_STARTABLE) begin
            s_d.flags[s_d.tail][FLG_START] = 1'b1;
            s_d.active = 1'b1;
            s_d.ptr    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    lr_word_store #(
        .SLOTS(SLOTS), .MAX_WORDS(MAX_WORDS), .DW(DW), .PRESET_SYNC(PRESET_SYNC)
    ) u_store (
        .clk        (clk),
        .preset_en  (claim_fire),
        .preset_slot(s_q.head),
        .wr_en      (wr_en),
        .wr_slot    (wr_slot),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .rd_slot    (s_q.tail),
        .rd_ptr     (s_q.ptr),
        .rd_len     (s_q.len[s_q.tail]),
        .rd_word    (o_data)
    );

    assign claim_ok   = !s_q.flags[s_q.head][FLG_BUSY];
    assign claim_slot = s_q.head;
    assign o_valid    = s_q.active;
    assign o_last     = s_q.active && at_term;
    assign o_slot     = s_q.tail;
endmodule

// File: rtl/lr_checker.sv
module lr_checker #(
    parameter int SW = 5,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          claim_req,
    input logic          claim_ok,
    input logic [SW-1:0] claim_slot,
    input logic          o_valid,
    input logic          o_ready,
    input logic [DW-1:0] o_data,
    input logic          o_last,
    input logic [SW-1:0] o_slot
);
    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid && !o_ready |=> o_valid && $stable(o_data));
    // R3
    stall_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        claim_req && !claim_ok |=> $stable(claim_slot));
    // R2
    head_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        claim_req && claim_ok |=> claim_slot == SW'($past(claim_slot) + 1'b1));
    // R6
    blank_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid && o_last |-> o_data == '0);
    // R11
    slot_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid && o_ready && !o_last |=> o_valid && $stable(o_slot));
endmodule

bind line_ring_ctrl lr_checker #(.SW(SW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .claim_req(claim_req), .claim_ok(claim_ok),
    .claim_slot(claim_slot), .o_valid(o_valid), .o_ready(o_ready),
    .o_data(o_data), .o_last(o_last), .o_slot(o_slot)
);

// File: tb/tb_line_ring_ctrl.sv
module tb_line_ring_ctrl;
    localparam int SLOTS = 32;
    localparam int MAXW  = 8;
    localparam int DW    = 32;
    localparam int RW    = 4;
    localparam int SW    = 5;
    localparam int LW    = 4;
    localparam logic [DW-1:0] PRESET = 32'h0002_0000;

    // stimulus table: data length, replay count, rewrite sync word
    localparam int NV = 8;
    localparam int VLEN  [NV] = '{3, 0, 8, 1, 5, 2, 8, 4};
    localparam int VREP  [NV] = '{0, 2, 1, 0, 3, 0, 0, 1};
    localparam int VSYNC [NV] = '{1, 0, 1, 1, 0, 1, 0, 0};

    logic clk = 0, rst_n = 0;
    logic claim_req = 0, claim_ok;
    logic [SW-1:0] claim_slot, o_slot;
    logic wr_en = 0, sub_en = 0, o_ready = 0, o_valid, o_last;
    logic [SW-1:0] wr_slot = '0, sub_slot = '0;
    logic [LW-1:0] wr_idx = '0, sub_len = '0;
    logic [DW-1:0] wr_data = '0, o_data;
    logic [RW-1:0] sub_rep = '0;

    int checks = 0, errors = 0, cyc = 0, rdy_mode = 2, claims = 0;
    logic [DW-1:0] exp_q[$];
    logic          exp_last_q[$];
    logic [DW-1:0] sync_model [SLOTS];

    always #2 clk = ~clk;

    line_ring_ctrl #(.SLOTS(SLOTS), .MAX_WORDS(MAXW), .DW(DW), .RW(RW),
                     .PRESET_SYNC(PRESET)) dut (.*);

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // consumer: drive ready and compare each word about to be accepted
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
        if (rst_n) begin
            o_ready = (rdy_mode == 0) || (rdy_mode == 1 && (cyc % 3) != 0);
            if (o_valid && o_ready) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R6 unexpected word", o_data, '0);
                end else begin
                    logic [DW-1:0] e;
                    logic el;
                    e  = exp_q.pop_front();
                    el = exp_last_q.pop_front();
                    // R6 R7 R11 word order and terminator
                    chk(o_data == e, "R6/R7/R11 word", o_data, e);
                    chk(o_last == el, "R6 last flag", DW'(o_last), DW'(el));
                end
            end
        end
    end

    task automatic do_claim(output int slot);
        while (!claim_ok) @(negedge clk);
        slot = int'(claim_slot);
        // R2 head index wraps modulo 32
        chk(slot == claims % SLOTS, "R2 head index", DW'(slot), DW'(claims % SLOTS));
        claims++;
        sync_model[slot] = PRESET;  // R4
        claim_req = 1;
        @(negedge clk);
        claim_req = 0;
    endtask

    task automatic do_write(input int slot, input int idx, input logic [DW-1:0] d);
        wr_en = 1; wr_slot = SW'(slot); wr_idx = LW'(idx); wr_data = d;
        if (idx == 0) sync_model[slot] = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic do_submit(input int slot, input int len, input int rep,
                             input logic [DW-1:0] base);
        for (int r = 0; r <= rep; r++) begin
            exp_q.push_back(sync_model[slot]); exp_last_q.push_back(1'b0);
            for (int k = 1; k <= len; k++) begin
                exp_q.push_back(base + DW'(k)); exp_last_q.push_back(1'b0);
            end
            exp_q.push_back('0); exp_last_q.push_back(1'b1);
        end
        sub_en = 1; sub_slot = SW'(slot); sub_len = LW'(len); sub_rep = RW'(rep);
        @(negedge clk);
        sub_en = 0;
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int s;
        logic [DW-1:0] held;
        logic [SW-1:0] h;
        int gaps;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(o_valid == 0, "R1 o_valid", DW'(o_valid), 0);
        chk(claim_ok == 1, "R1 claim_ok", DW'(claim_ok), 1);
        chk(claim_slot == 0, "R1 claim_slot", DW'(claim_slot), 0);

        // R8 start on submit when idle; R5 sync write; R9 hold
        rdy_mode = 2;
        do_claim(s);
        do_write(s, 0, 32'h5A5A_0001);
        do_write(s, 1, 32'hC000_0001);
        do_write(s, 2, 32'hC000_0002);
        do_submit(s, 2, 1, 32'hC000_0000);
        chk(o_valid == 1, "R8 valid after submit edge", DW'(o_valid), 1);
        chk(o_data == 32'h5A5A_0001, "R5 sync word", o_data, 32'h5A5A_0001);
        held = o_data;
        repeat (3) @(negedge clk);
        chk(o_valid == 1 && o_data == held, "R9 hold while not ready", o_data, held);
        rdy_mode = 0;
        drain();

        // table-driven lines, 40 of them so slots wrap and get reused (R2, R4)
        rdy_mode = 1;
        for (int line = 0; line < 40; line++) begin
            int e;
            logic [DW-1:0] base;
            e = line % NV;
            base = 32'hD000_0000 | (DW'(line) << 8);
            do_claim(s);
            if (VSYNC[e] != 0) do_write(s, 0, 32'h5100_0000 | DW'(line));
            for (int k = 1; k <= VLEN[e]; k++) do_write(s, k, base + DW'(k));
            do_submit(s, VLEN[e], VREP[e], base);
        end
        drain();

        // fill the whole ring with the consumer stalled (R3), sync left preset (R4)
        rdy_mode = 2;
        for (int i = 0; i < SLOTS; i++) begin
            logic [DW-1:0] base;
            base = 32'hE000_0000 | (DW'(i) << 8);
            do_claim(s);
            do_write(s, 1, base + 1);
            do_submit(s, 1, 0, base);
        end
        chk(claim_ok == 0, "R3 claim_ok low when full", DW'(claim_ok), 0);
        h = claim_slot;
        held = o_data;
        claim_req = 1;
        @(negedge clk);
        claim_req = 0;
        chk(claim_slot == h, "R3 head holds on stalled claim", DW'(claim_slot), DW'(h));
        chk(o_data == PRESET, "R4 preset sync", o_data, PRESET);
        chk(o_data == held && o_valid, "R9 stalled word stable", o_data, held);

        // R10 back-to-back drain with no idle cycles
        rdy_mode = 0;
        gaps = 0;
        while (exp_q.size() > 0) begin
            @(negedge clk);
            if (!o_valid && exp_q.size() > 0) gaps++;
        end
        chk(gaps == 0, "R10 idle cycles between lines", DW'(gaps), 0);
        repeat (2) @(negedge clk);
        chk(claim_ok == 1, "R10 slot freed after completion", DW'(claim_ok), 1);
        chk(o_valid == 0, "R10 idle when ring empty", DW'(o_valid), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule